// File: doc/BRIEF.md
# Vblank Evasion Update Gate

This block decides when a batch of display register writes may begin, so that the whole batch lands within a single frame. It observes the current scanline and the frame counter of a display timing generator. From a microsecond budget, the pixel clock and the line length, it works out how many scanlines that budget covers. That count sets a guard window that ends just before vertical blank. A requester that strobes `start_req` while the scanline is inside the window is held until the scanline leaves the window or a cycle timeout expires. Otherwise it is granted at once.

At grant the block captures the frame count and the scanline. The requester then performs its writes and strobes `end_req`. At that point the block captures the end frame count and end scanline. It raises a failure flag if the batch crossed a frame boundary. The window bounds and the captured values are exposed as status outputs for diagnosis.

Top module: `vblank_gate`

## Requirements
- R1: The guard band in scanlines is G = ceil(BUDGET_US × pix_khz / (1000 × htotal)). `win_hi` = V − 1 and `win_lo` = V − G, where V is the effective vblank start line. Either output reads 0 when its bound is zero or negative. Both outputs are combinational from the timing inputs.
- R2: When `htotal` is 0, G is forced to 1.
- R3: When `interlaced` is 1, V = ceil(vblank_start / 2). Otherwise V = vblank_start.
- R4: In the idle state, a `start_req` produces a grant on the next clock edge in either of two cases: the scanline is below `win_lo` or above `win_hi`, or either bound is zero or negative. The grant is a one-cycle `grant` pulse. `busy` rises on the same edge.
- R5: A `start_req` seen while the scanline lies in [V−G, V−1] (both ends included) is held. The grant follows on the first clock edge at which the scanline is observed outside that range.
- R6: If the scanline stays inside the window for TIMEOUT_CYC edges after the wait began, the block grants anyway and sets `timeout_flag` to 1. Every grant updates `timeout_flag`: to 1 for a timeout grant and to 0 otherwise. The flag holds its value until the next grant.
- R7: On the granting edge, `start_frame` and `start_line` capture `frame_cnt` and `scanline` as sampled on that edge.
- R8: An `end_req` while `busy` is 1 has three effects on the next edge. `busy` falls. `end_frame` and `end_line` capture the inputs. `fail_flag` becomes 1 exactly when `start_frame` is nonzero and differs from the end frame count.
- R9: A `start_req` while waiting or busy has no effect. An `end_req` while not busy has no effect.
- R10: After reset, `grant`, `busy`, `timeout_flag`, `fail_flag` and all captured values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| htotal | input | LINE_W | Total pixels per line |
| vblank_start | input | LINE_W | First line of vertical blank |
| interlaced | input | 1 | Interlaced timing selected |
| pix_khz | input | CLK_W | Pixel clock in kHz |
| scanline | input | LINE_W | Current scanline |
| frame_cnt | input | CNT_W | Current frame counter |
| start_req | input | 1 | Request to begin an update |
| end_req | input | 1 | Update finished |
| grant | output | 1 | One-cycle permission to begin writing |
| busy | output | 1 | Update in progress, from grant to end |
| timeout_flag | output | 1 | Last grant was forced by timeout |
| fail_flag | output | 1 | Last update crossed a frame boundary |
| win_lo | output | LINE_W | Lower window bound, 0 if nonpositive |
| win_hi | output | LINE_W | Upper window bound, 0 if nonpositive |
| start_line | output | LINE_W | Scanline captured at grant |
| end_line | output | LINE_W | Scanline captured at end |
| start_frame | output | CNT_W | Frame count captured at grant |
| end_frame | output | CNT_W | Frame count captured at end |

## Verification
The window bounds are combinational and due in the same cycle as the timing inputs. `grant`, `busy`, the captured values and both flags change on the first rising edge that samples the deciding strobe or scanline. A timed-out wait grants on the edge TIMEOUT_CYC edges after the one that entered the wait. The bench drives inputs just after a falling edge and runs a behavioural model on each rising edge. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due. Directed checks at the window edges, the timeout instant and the zero-count exemption pin down the boundary values.

// File: rtl/vblank_gate.sv
module vblank_gate #(
  parameter int LINE_W      = 13,
  parameter int CNT_W       = 16,
  parameter int CLK_W       = 20,
  parameter int BUDGET_US   = 100,
  parameter int TIMEOUT_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] htotal,
  input  logic [LINE_W-1:0] vblank_start,
  input  logic              interlaced,
  input  logic [CLK_W-1:0]  pix_khz,
  input  logic [LINE_W-1:0] scanline,
  input  logic [CNT_W-1:0]  frame_cnt,
  input  logic              start_req,
  input  logic              end_req,
  output logic              grant,
  output logic              busy,
  output logic              timeout_flag,
  output logic              fail_flag,
  output logic [LINE_W-1:0] win_lo,
  output logic [LINE_W-1:0] win_hi,
  output logic [LINE_W-1:0] start_line,
  output logic [LINE_W-1:0] end_line,
  output logic [CNT_W-1:0]  start_frame,
  output logic [CNT_W-1:0]  end_frame
);
  localparam int MW    = 48;
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_BUSY} state_t;
  state_t st;
  logic [TMO_W-1:0] tmo;

  logic [MW-1:0] num, den, guard;
  logic [LINE_W:0] vb_sum;
  logic [LINE_W-1:0] vb_eff;
  logic signed [MW:0] lo_s, hi_s, line_s;
  logic no_wait, in_win, tmo_hit, do_grant, do_tmo;

  assign num    = MW'(BUDGET_US) * MW'(pix_khz);
  assign den    = (htotal == '0) ? MW'(1) : MW'(1000) * MW'(htotal);
  assign guard  = (htotal == '0) ? MW'(1) : (num + den - MW'(1)) / den;
  assign vb_sum = {1'b0, vblank_start} + (LINE_W+1)'(1);
  assign vb_eff = interlaced ? vb_sum[LINE_W:1] : vblank_start;

  assign lo_s   = $signed({1'b0, MW'(vb_eff)}) - $signed({1'b0, guard});
  assign hi_s   = $signed({1'b0, MW'(vb_eff)}) - 1;
  assign line_s = $signed({1'b0, MW'(scanline)});

  assign no_wait = (lo_s <= 0) || (hi_s <= 0);
  assign in_win  = !no_wait && (line_s >= lo_s) && (line_s <= hi_s);
  assign win_lo  = (lo_s > 0) ? LINE_W'(lo_s) : '0;
  assign win_hi  = (hi_s > 0) ? LINE_W'(hi_s) : '0;

  assign tmo_hit  = (tmo == TMO_W'(TIMEOUT_CYC - 1));
  assign do_tmo   = (st == S_WAIT) && in_win && tmo_hit;
  assign do_grant = ((st == S_IDLE) && start_req && !in_win) ||
                    ((st == S_WAIT) && (!in_win || tmo_hit));
  assign busy     = (st == S_BUSY);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      tmo          <= '0;
      grant        <= 1'b0;
      timeout_flag <= 1'b0;
      fail_flag    <= 1'b0;
      start_line   <= '0;
      end_line     <= '0;
      start_frame  <= '0;
      end_frame    <= '0;
    end else begin
      grant <= 1'b0;
      if (do_grant) begin
        st           <= S_BUSY;
        grant        <= 1'b1;
        timeout_flag <= do_tmo;
        start_line   <= scanline;
        start_frame  <= frame_cnt;
      end else if (st == S_IDLE && start_req) begin
        st  <= S_WAIT;
        tmo <= '0;
      end else if (st == S_WAIT) begin
        tmo <= tmo + TMO_W'(1);
      end else if (st == S_BUSY && end_req) begin
        st        <= S_IDLE;
        end_line  <= scanline;
        end_frame <= frame_cnt;
        fail_flag <= (start_frame != '0) && (start_frame != frame_cnt);
      end
    end
  end
endmodule

module vblank_gate_chk (
  input logic clk,
  input logic rst,
  input logic start_req,
  input logic end_req,
  input logic grant,
  input logic busy,
  input logic timeout_flag,
  input logic fail_flag
);
  // R4
  grant_pulse_chk: assert property (@(posedge clk) disable iff (rst) grant |=> !grant);
  // R4
  grant_busy_chk: assert property (@(posedge clk) disable iff (rst) grant |-> busy);
  // R4
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> grant);
  // R6
  tmo_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(timeout_flag) |-> grant);
  // R8
  end_drop_chk: assert property (@(posedge clk) disable iff (rst) (busy && end_req) |=> !busy);
  // R9
  idle_end_chk: assert property (@(posedge clk) disable iff (rst) (!busy && end_req) |=> $stable(fail_flag));
  // R8
  fail_src_chk: assert property (@(posedge clk) disable iff (rst) !$stable(fail_flag) |-> $past(busy && end_req));
endmodule

bind vblank_gate vblank_gate_chk u_chk (
  .clk(clk), .rst(rst), .start_req(start_req), .end_req(end_req),
  .grant(grant), .busy(busy), .timeout_flag(timeout_flag), .fail_flag(fail_flag)
);

// File: tb/tb_vblank_gate.sv
module tb_vblank_gate;
  localparam int LW = 11, CW = 8, KW = 20, TMO = 20;

  logic clk = 1'b0, rst = 1'b1;
  logic [LW-1:0] htotal, vblank_start, scanline;
  logic interlaced;
  logic [KW-1:0] pix_khz;
  logic [CW-1:0] frame_cnt;
  logic start_req, end_req;
  logic grant, busy, timeout_flag, fail_flag;
  logic [LW-1:0] win_lo, win_hi, start_line, end_line;
  logic [CW-1:0] start_frame, end_frame;

  int checks = 0, failures = 0, cyc = 0;

  vblank_gate #(.LINE_W(LW), .CNT_W(CW), .CLK_W(KW), .BUDGET_US(100), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .htotal(htotal), .vblank_start(vblank_start), .interlaced(interlaced),
    .pix_khz(pix_khz), .scanline(scanline), .frame_cnt(frame_cnt), .start_req(start_req),
    .end_req(end_req), .grant(grant), .busy(busy), .timeout_flag(timeout_flag),
    .fail_flag(fail_flag), .win_lo(win_lo), .win_hi(win_hi), .start_line(start_line),
    .end_line(end_line), .start_frame(start_frame), .end_frame(end_frame));

  always #2 clk = ~clk;

  // behavioural reference
  int m_state = 0, m_wait = 0;
  int m_grant = 0, m_tmo = 0, m_fail = 0, m_sl = 0, m_sf = 0, m_el = 0, m_ef = 0;

  function automatic void window(output int lo, output int hi);
    longint g;
    int v;
    if (htotal == 0) g = 1;
    else g = (100 * longint'(pix_khz) + 1000 * longint'(htotal) - 1) / (1000 * longint'(htotal));
    v = interlaced ? (int'(vblank_start) + 1) / 2 : int'(vblank_start);
    lo = (longint'(v) - g < -1000) ? -1000 : int'(longint'(v) - g);
    hi = v - 1;
  endfunction

  function automatic bit inside_win();
    int lo, hi;
    window(lo, hi);
    if (lo <= 0 || hi <= 0) return 1'b0;
    return (int'(scanline) >= lo) && (int'(scanline) <= hi);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_wait = 0; m_grant = 0; m_tmo = 0; m_fail = 0;
      m_sl = 0; m_sf = 0; m_el = 0; m_ef = 0;
    end else begin
      bit inw, give, tm;
      inw = inside_win();
      give = 0; tm = 0;
      m_grant = 0;
      if (m_state == 0) begin
        if (start_req) begin
          if (inw) begin m_state = 1; m_wait = 0; end
          else give = 1;
        end
      end else if (m_state == 1) begin
        if (!inw) give = 1;
        else if (m_wait == TMO - 1) begin give = 1; tm = 1; end
        else m_wait++;
      end else if (end_req) begin
        m_state = 0;
        m_el = scanline; m_ef = frame_cnt;
        m_fail = (m_sf != 0 && m_sf != int'(frame_cnt)) ? 1 : 0;
      end
      if (give) begin
        m_state = 2; m_grant = 1; m_tmo = tm;
        m_sl = scanline; m_sf = frame_cnt;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int lo, hi;
    window(lo, hi);
    chk("R1 win_lo", int'(win_lo), lo > 0 ? lo : 0);
    chk("R1 win_hi", int'(win_hi), hi > 0 ? hi : 0);
    chk("R5 grant", int'(grant), m_grant);
    chk("R4 busy", int'(busy), m_state == 2 ? 1 : 0);
    chk("R6 timeout_flag", int'(timeout_flag), m_tmo);
    chk("R7 start_line", int'(start_line), m_sl);
    chk("R7 start_frame", int'(start_frame), m_sf);
    chk("R8 end_line", int'(end_line), m_el);
    chk("R8 end_frame", int'(end_frame), m_ef);
    chk("R8 fail_flag", int'(fail_flag), m_fail);
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic pulse_start();
    start_req = 1'b1; tick(); start_req = 1'b0;
  endtask

  task automatic pulse_end();
    end_req = 1'b1; tick(); end_req = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      summary();
    end
  end

  initial begin
    htotal = 100; pix_khz = 10000; vblank_start = 50; interlaced = 0;
    scanline = 10; frame_cnt = 5; start_req = 0; end_req = 0;
    repeat (3) tick();
    rst = 0;
    tick();
    // R10 reset state
    chk("R10 busy", int'(busy), 0);
    chk("R10 grant", int'(grant), 0);
    chk("R10 fail_flag", int'(fail_flag), 0);
    chk("R10 start_frame", int'(start_frame), 0);
    // R1 guard = ceil(100*10000/100000) = 10
    chk("R1 lo", int'(win_lo), 40);
    chk("R1 hi", int'(win_hi), 49);

    // R4 immediate grant outside window
    pulse_start();
    chk("R4 grant now", int'(grant), 1);
    chk("R7 line", int'(start_line), 10);
    chk("R7 frame", int'(start_frame), 5);
    tick();
    chk("R4 single pulse", int'(grant), 0);
    chk("R4 busy held", int'(busy), 1);
    // R9 start while busy
    pulse_start();
    chk("R9 no regrant", int'(grant), 0);
    scanline = 20;
    pulse_end();
    chk("R8 busy drop", int'(busy), 0);
    chk("R8 end_line", int'(end_line), 20);
    chk("R8 no fail", int'(fail_flag), 0);
    // R9 end while idle
    scanline = 33;
    pulse_end();
    chk("R9 end_line kept", int'(end_line), 20);

    // R5 hold inside window, inclusive edges
    scanline = 45;
    pulse_start();
    chk("R5 held", int'(grant), 0);
    scanline = 40; tick();
    chk("R5 held at lo", int'(grant), 0);
    scanline = 49;
    pulse_start();
    chk("R5 held at hi", int'(grant), 0);
    scanline = 50; frame_cnt = 5; tick();
    chk("R5 release", int'(grant), 1);
    chk("R7 line at release", int'(start_line), 50);
    tick();
    frame_cnt = 6;
    pulse_end();
    chk("R8 crossed frame", int'(fail_flag), 1);

    scanline = 39;
    pulse_start();
    chk("R5 below lo", int'(grant), 1);
    pulse_end();
    chk("R8 same frame", int'(fail_flag), 0);

    // R6 timeout
    scanline = 45;
    pulse_start();
    for (int i = 0; i < TMO - 1; i++) tick();
    chk("R6 still held", int'(grant), 0);
    tick();
    chk("R6 timeout grant", int'(grant), 1);
    chk("R6 timeout flag", int'(timeout_flag), 1);
    tick();
    pulse_end();
    scanline = 5;
    pulse_start();
    chk("R6 flag cleared", int'(timeout_flag), 0);
    tick();
    // R8 zero start count exempt
    pulse_end();
    frame_cnt = 0;
    pulse_start();
    frame_cnt = 1;
    pulse_end();
    chk("R8 zero start", int'(fail_flag), 0);

    // R2 htotal zero
    htotal = 0;
    tick();
    chk("R2 lo", int'(win_lo), 49);
    chk("R2 hi", int'(win_hi), 49);
    scanline = 48;
    pulse_start();
    chk("R2 grant at 48", int'(grant), 1);
    pulse_end();
    scanline = 49;
    pulse_start();
    chk("R2 held at 49", int'(grant), 0);
    scanline = 48; tick();
    chk("R2 release", int'(grant), 1);
    pulse_end();

    // R3 interlaced: V = ceil(51/2) = 26
    htotal = 100; interlaced = 1; vblank_start = 51;
    tick();
    chk("R3 lo", int'(win_lo), 16);
    chk("R3 hi", int'(win_hi), 25);
    scanline = 16;
    pulse_start();
    chk("R3 held", int'(grant), 0);
    scanline = 26; tick();
    chk("R3 release", int'(grant), 1);
    pulse_end();

    // R4 nonpositive bound: V=5, lo=-5
    interlaced = 0; vblank_start = 5;
    tick();
    chk("R4 lo clamp", int'(win_lo), 0);
    chk("R4 hi", int'(win_hi), 4);
    scanline = 3;
    pulse_start();
    chk("R4 bypass grant", int'(grant), 1);
    pulse_end();
    vblank_start = 0;
    tick();
    chk("R4 hi clamp", int'(win_hi), 0);
    pulse_start();
    chk("R4 bypass zero", int'(grant), 1);
    pulse_end();
    repeat (3) tick();
    summary();
  end
endmodule